// File: doc/BRIEF.md
# Error Response Capture Queue

This block sits behind the response decoder of a serial memory link. Every decoded response enters on a one-cycle `rspValid` strobe together with a kind code, a 7-bit error status and a tag. Error Response packets are not handed to the data path. The block keeps their error status and cube ID in a small FIFO. The other response kinds (read, write and mode) go to a registered data-path port, and a flag on that port marks the ones whose error status is non-zero.

Software drains the FIFO through a 32-bit read-only queue register on a simple CSR bus. The read data is combinational. Each read of the queue register removes the entry at the head. The block also has an interrupt status register with a pending source and an overflow source, a per-source enable register and a global enable. Together they gate a single `irq` output. Software can use the interrupt in place of polling the valid bit.

Top module: `errq_top`

## Requirements
- R1: A response with `rspKind` = 3 (error response) is queued. The entry holds `rspErrStat[6:0]` and a cube ID taken from `rspTag[2:0]`. Entries leave the queue in arrival order.
- R2: A read at CSR byte offset 0x0 returns the head entry: bit 16 = valid, bits 10:8 = cube ID, bits 6:0 = error status, and every other bit is 0. When the queue is empty, the whole word is 0.
- R3: A CSR read of offset 0x0 pops one entry on that clock edge. A read of an empty queue changes nothing.
- R4: Kinds 0 (read), 1 (write) and 2 (mode) appear on `dpValid`/`dpKind`/`dpTag` one cycle after `rspValid`. `dpError` is 1 exactly when their error status is non-zero. Kind 3 never raises `dpValid`.
- R5: The queue holds 16 entries. An error response that arrives while the queue is full, with no pop in the same cycle, is dropped, and status bit 1 (overflow) is set on that edge. The bit stays set until it is cleared.
- R6: A push and a pop in the same cycle both take effect and leave the occupancy unchanged. This also holds when the queue is full, and no overflow is flagged in that case.
- R7: Status bit 0 (pending) sets one cycle after the queue becomes non-empty. Status lives at offset 0x4, and writing 1 to a bit clears it. A cleared pending bit sets again on the following edge if entries remain.
- R8: `irq` = global enable (offset 0xC, bit 0) AND any status bit whose enable bit (offset 0x8, bits 1:0) is set. These registers read back what was written.
- R9: Reset empties the queue and clears the status, enable and global-enable bits, the data-path outputs and `irq`.
- R10: A CSR write to offset 0x0 has no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rspValid | input | 1 | A decoded response is present this cycle |
| rspKind | input | 2 | 0 read, 1 write, 2 mode, 3 error response |
| rspErrStat | input | 7 | Error status field of the response |
| rspTag | input | 11 | Tag field; bits 2:0 carry the cube ID |
| dpValid | output | 1 | Forwarded non-error-kind response |
| dpKind | output | 2 | Kind of the forwarded response |
| dpTag | output | 11 | Tag of the forwarded response |
| dpError | output | 1 | Forwarded response had a non-zero error status |
| csrAddr | input | 4 | CSR byte offset |
| csrRead | input | 1 | CSR read strobe |
| csrWrite | input | 1 | CSR write strobe |
| csrWdata | input | 32 | CSR write data |
| csrRdata | output | 32 | CSR read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Two things can land on the same clock edge: an incoming error response pushing into the queue, and a software read of the queue register popping it. The bench forces this by raising `rspValid` with kind 3 and `csrRead` at offset 0x0 in one cycle. It does so once with the queue partly filled and once with the queue full. It then judges the result from the returned head word, from the absence of an overflow flag, and by draining the queue and comparing every entry and the total count against its own model.

// File: rtl/errq_pkg.sv
package errq_pkg;
  localparam int ERRSTAT_W = 7;
  localparam int CUB_W     = 3;
  localparam int ENTRY_W   = ERRSTAT_W + CUB_W;
  localparam int NUM_SRC   = 2;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_MODE  = 2'd2,
    KIND_ERROR = 2'd3
  } rspKind_e;

  localparam logic [3:0] OFS_QUEUE  = 4'h0;
  localparam logic [3:0] OFS_STATUS = 4'h4;
  localparam logic [3:0] OFS_ENABLE = 4'h8;
  localparam logic [3:0] OFS_GLOBAL = 4'hC;

  localparam int SRC_PEND = 0;
  localparam int SRC_OVF  = 1;

  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;
endpackage

// File: rtl/errq_store.sv
module errq_store
  import errq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  qStrobe_t           strobe,
  input  logic [ENTRY_W-1:0] inEntry,
  output logic [ENTRY_W-1:0] headEntry,
  output logic               empty,
  output logic               full,
  output logic [CNT_W-1:0]   occupancy
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= inEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end

  assign empty     = (occupancy == '0);
  assign full      = (occupancy == FULL_CNT);
  assign headEntry = empty ? '0 : mem[rdPtr];
endmodule

// File: rtl/errq_ctrl.sv
module errq_ctrl
  import errq_pkg::*;
#(
  parameter int TAG_W = 11
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rspValid,
  input  logic [1:0]         rspKind,
  input  logic [6:0]         rspErrStat,
  input  logic [TAG_W-1:0]   rspTag,
  output logic               dpValid,
  output logic [1:0]         dpKind,
  output logic [TAG_W-1:0]   dpTag,
  output logic               dpError,
  input  logic [3:0]         csrAddr,
  input  logic               csrRead,
  input  logic               csrWrite,
  input  logic [31:0]        csrWdata,
  output logic [31:0]        csrRdata,
  output logic               irq,
  input  logic               empty,
  input  logic               full,
  input  logic [ENTRY_W-1:0] headEntry,
  output qStrobe_t           strobe,
  output logic [ENTRY_W-1:0] inEntry,
  output logic [NUM_SRC-1:0] statusBits,
  output logic [NUM_SRC-1:0] enableBits,
  output logic               globalEn
);
  logic isErrRsp, isDataRsp, rdQueue, ovfEvent;
  logic [NUM_SRC-1:0] clearMask, setMask;
  logic unusedWdata;

  assign isErrRsp  = rspValid && (rspKind_e'(rspKind) == KIND_ERROR);
  assign isDataRsp = rspValid && (rspKind_e'(rspKind) != KIND_ERROR);
  assign rdQueue   = csrRead && (csrAddr == OFS_QUEUE);

  assign strobe.pop  = rdQueue && !empty;
  assign strobe.push = isErrRsp && (!full || strobe.pop);
  assign ovfEvent    = isErrRsp && full && !strobe.pop;
  assign inEntry     = {rspTag[CUB_W-1:0], rspErrStat};

  assign clearMask = (csrWrite && csrAddr == OFS_STATUS) ? csrWdata[NUM_SRC-1:0] : '0;
  assign setMask[SRC_PEND] = !empty;
  assign setMask[SRC_OVF]  = ovfEvent;
  assign unusedWdata = ^csrWdata[31:NUM_SRC];

  // Pending source tracks occupancy; overflow source is an event latch.
  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (s == SRC_PEND) begin : g_level
        always_ff @(posedge clk) begin
          if (!rstN) statusBits[s] <= 1'b0;
          else       statusBits[s] <= !clearMask[s] && (statusBits[s] || setMask[s]);
        end
      end else begin : g_event
        always_ff @(posedge clk) begin
          if (!rstN) statusBits[s] <= 1'b0;
          else       statusBits[s] <= setMask[s] || (statusBits[s] && !clearMask[s]);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableBits <= '0;
      globalEn   <= 1'b0;
    end else if (csrWrite) begin
      if (csrAddr == OFS_ENABLE) enableBits <= csrWdata[NUM_SRC-1:0];
      if (csrAddr == OFS_GLOBAL) globalEn   <= csrWdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dpValid <= 1'b0;
      dpKind  <= '0;
      dpTag   <= '0;
      dpError <= 1'b0;
    end else begin
      dpValid <= isDataRsp;
      dpKind  <= rspKind;
      dpTag   <= rspTag;
      dpError <= isDataRsp && (rspErrStat != '0);
    end
  end

  assign irq = globalEn && |(statusBits & enableBits);

  always_comb begin
    csrRdata = '0;
    unique case (csrAddr)
      OFS_QUEUE: begin
        csrRdata[16]   = !empty;
        csrRdata[10:8] = headEntry[ENTRY_W-1:ERRSTAT_W];
        csrRdata[6:0]  = headEntry[ERRSTAT_W-1:0];
      end
      OFS_STATUS: csrRdata[NUM_SRC-1:0] = statusBits;
      OFS_ENABLE: csrRdata[NUM_SRC-1:0] = enableBits;
      OFS_GLOBAL: csrRdata[0]           = globalEn;
      default:    csrRdata = '0;
    endcase
  end
endmodule

// File: rtl/errq_top.sv
module errq_top
  import errq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TAG_W = 11,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rspValid,
  input  logic [1:0]       rspKind,
  input  logic [6:0]       rspErrStat,
  input  logic [TAG_W-1:0] rspTag,
  output logic             dpValid,
  output logic [1:0]       dpKind,
  output logic [TAG_W-1:0] dpTag,
  output logic             dpError,
  input  logic [3:0]       csrAddr,
  input  logic             csrRead,
  input  logic             csrWrite,
  input  logic [31:0]      csrWdata,
  output logic [31:0]      csrRdata,
  output logic             irq
);
  qStrobe_t           strobe;
  logic [ENTRY_W-1:0] inEntry, headEntry;
  logic               empty, full;
  logic [CNT_W-1:0]   occupancy;
  logic [NUM_SRC-1:0] statusBits, enableBits;
  logic               globalEn;

  errq_ctrl #(.TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .rspValid(rspValid), .rspKind(rspKind), .rspErrStat(rspErrStat), .rspTag(rspTag),
    .dpValid(dpValid), .dpKind(dpKind), .dpTag(dpTag), .dpError(dpError),
    .csrAddr(csrAddr), .csrRead(csrRead), .csrWrite(csrWrite), .csrWdata(csrWdata),
    .csrRdata(csrRdata), .irq(irq),
    .empty(empty), .full(full), .headEntry(headEntry),
    .strobe(strobe), .inEntry(inEntry),
    .statusBits(statusBits), .enableBits(enableBits), .globalEn(globalEn)
  );

  errq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inEntry(inEntry),
    .headEntry(headEntry), .empty(empty), .full(full), .occupancy(occupancy)
  );
endmodule

// File: rtl/errq_checker.sv
module errq_checker
  import errq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               rspValid,
  input logic [1:0]         rspKind,
  input logic [6:0]         rspErrStat,
  input logic               dpValid,
  input logic               dpError,
  input logic [3:0]         csrAddr,
  input logic               csrRead,
  input logic [31:0]        csrRdata,
  input logic               irq,
  input qStrobe_t           strobe,
  input logic [CNT_W-1:0]   occupancy,
  input logic [NUM_SRC-1:0] statusBits,
  input logic               globalEn
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  p_err_not_forwarded_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 2'd3) |=> !dpValid);

  p_data_err_flag_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind != 2'd3 && rspErrStat != '0) |=> (dpValid && dpError));

  p_empty_word_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == 4'h0 && !csrRdata[16]) |-> (csrRdata == '0));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= FULL_CNT);

  p_overflow_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 2'd3 && occupancy == FULL_CNT && !(csrRead && csrAddr == 4'h0))
    |=> statusBits[SRC_OVF]);

  p_push_pop_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.pop) |=> $stable(occupancy));

  p_empty_read_still_r3: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy == '0 && !rspValid) |=> (occupancy == '0));

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (globalEn && statusBits != '0));
endmodule

bind errq_top errq_checker #(.DEPTH(DEPTH)) u_checker (
  .clk(clk), .rstN(rstN), .rspValid(rspValid), .rspKind(rspKind),
  .rspErrStat(rspErrStat), .dpValid(dpValid), .dpError(dpError),
  .csrAddr(csrAddr), .csrRead(csrRead), .csrRdata(csrRdata), .irq(irq),
  .strobe(strobe), .occupancy(occupancy), .statusBits(statusBits), .globalEn(globalEn)
);

// File: tb/test_errq_top.sv
module test_errq_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        rspValid;
  logic [1:0]  rspKind;
  logic [6:0]  rspErrStat;
  logic [10:0] rspTag;
  logic        dpValid;
  logic [1:0]  dpKind;
  logic [10:0] dpTag;
  logic        dpError;
  logic [3:0]  csrAddr;
  logic        csrRead, csrWrite;
  logic [31:0] csrWdata, csrRdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  errq_top i_errq_top (
    .clk(clk), .rstN(rstN), .rspValid(rspValid), .rspKind(rspKind),
    .rspErrStat(rspErrStat), .rspTag(rspTag), .dpValid(dpValid), .dpKind(dpKind),
    .dpTag(dpTag), .dpError(dpError), .csrAddr(csrAddr), .csrRead(csrRead),
    .csrWrite(csrWrite), .csrWdata(csrWdata), .csrRdata(csrRdata), .irq(irq)
  );

  // {expDpValid, expDpError, kind, errStat, tag}
  localparam logic [21:0] VEC [8] = '{
    {1'b1, 1'b0, 2'd0, 7'h00, 11'h005},
    {1'b1, 1'b1, 2'd1, 7'h12, 11'h0A3},
    {1'b0, 1'b0, 2'd3, 7'h21, 11'h1FD},
    {1'b1, 1'b1, 2'd2, 7'h7F, 11'h002},
    {1'b0, 1'b0, 2'd3, 7'h05, 11'h00A},
    {1'b1, 1'b1, 2'd0, 7'h40, 11'h3FF},
    {1'b0, 1'b0, 2'd3, 7'h7F, 11'h007},
    {1'b1, 1'b0, 2'd2, 7'h00, 11'h100}
  };

  logic [9:0] model [64];
  int mHead = 0;
  int mTail = 0;

  function automatic logic [31:0] qWord(input logic v, input logic [2:0] cub, input logic [6:0] es);
    return {15'b0, v, 5'b0, cub, 1'b0, es};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic sendRsp(input logic [1:0] k, input logic [6:0] es, input logic [10:0] tg);
    rspValid = 1'b1; rspKind = k; rspErrStat = es; rspTag = tg;
    @(negedge clk);
    rspValid = 1'b0;
  endtask

  task automatic csrRd(input logic [3:0] a, output logic [31:0] d);
    csrAddr = a; csrRead = 1'b1;
    #1 d = csrRdata;
    @(negedge clk);
    csrRead = 1'b0;
  endtask

  task automatic csrWr(input logic [3:0] a, input logic [31:0] d);
    csrAddr = a; csrWdata = d; csrWrite = 1'b1;
    @(negedge clk);
    csrWrite = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(); idle();
    rstN = 1'b1;
    idle();
  endtask

  initial begin
    #(5ns * 20000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rspValid = 0; rspKind = 0; rspErrStat = 0; rspTag = 0;
    csrAddr = 0; csrRead = 0; csrWrite = 0; csrWdata = 0;
    rstN = 1'b0;
    idle(); idle();
    rstN = 1'b1;
    idle();

    // R9 reset state
    csrRd(4'h0, d); check("R9 queue after reset", d, 32'h0);
    csrRd(4'h4, d); check("R9 status after reset", d, 32'h0);
    check("R9 irq after reset", {31'b0, irq}, 32'h0);
    check("R9 dpValid after reset", {31'b0, dpValid}, 32'h0);

    // R4/R1 vector walk
    for (int i = 0; i < 8; i++) begin
      sendRsp(VEC[i][19:18], VEC[i][17:11], VEC[i][10:0]);
      check("R4 dpValid", {31'b0, dpValid}, {31'b0, VEC[i][21]});
      if (VEC[i][21]) begin
        check("R4 dpError", {31'b0, dpError}, {31'b0, VEC[i][20]});
        check("R4 dpTag", {21'b0, dpTag}, {21'b0, VEC[i][10:0]});
        check("R4 dpKind", {30'b0, dpKind}, {30'b0, VEC[i][19:18]});
      end
      if (VEC[i][19:18] == 2'd3) begin
        model[mTail] = {VEC[i][2:0], VEC[i][17:11]};
        mTail++;
      end
    end

    // R1/R2/R3 drain in order
    while (mHead < mTail) begin
      csrRd(4'h0, d);
      check("R1 R2 queue head", d, qWord(1'b1, model[mHead][9:7], model[mHead][6:0]));
      mHead++;
    end
    csrRd(4'h0, d); check("R2 empty word", d, 32'h0);

    // R3 empty read leaves pointers; R10 write ignored
    sendRsp(2'd3, 7'h2C, 11'h7F6);
    csrWr(4'h0, 32'hFFFF_FFFF);
    csrRd(4'h0, d); check("R3 R10 head after empty read and write", d, qWord(1'b1, 3'd6, 7'h2C));
    csrRd(4'h0, d); check("R3 popped", d, 32'h0);

    // R7/R8 interrupt path
    sendRsp(2'd3, 7'h11, 11'h001);
    idle();
    csrRd(4'h4, d); check("R7 pending set", d, 32'h1);
    check("R8 irq off with enables clear", {31'b0, irq}, 32'h0);
    csrWr(4'h8, 32'h1);
    check("R8 irq off with global clear", {31'b0, irq}, 32'h0);
    csrRd(4'h8, d); check("R8 enable readback", d, 32'h1);
    csrWr(4'hC, 32'h1);
    check("R8 irq on", {31'b0, irq}, 32'h1);
    csrWr(4'h4, 32'h1);
    check("R7 cleared by write-1", {31'b0, irq}, 32'h0);
    idle();
    check("R7 pending re-sets while non-empty", {31'b0, irq}, 32'h1);
    csrRd(4'h0, d); check("R1 entry behind interrupt", d, qWord(1'b1, 3'd1, 7'h11));
    csrWr(4'h4, 32'h1);
    idle();
    csrRd(4'h4, d); check("R7 stays clear when empty", d, 32'h0);
    check("R8 irq low when empty", {31'b0, irq}, 32'h0);

    // R5 overflow
    for (int i = 0; i < 17; i++) sendRsp(2'd3, 7'(i + 1), 11'(i));
    csrRd(4'h4, d); check("R5 overflow and pending", d, 32'h3);
    for (int i = 0; i < 16; i++) begin
      csrRd(4'h0, d); check("R5 kept entry", d, qWord(1'b1, 3'(i), 7'(i + 1)));
    end
    csrRd(4'h0, d); check("R5 17th dropped", d, 32'h0);
    csrRd(4'h4, d); check("R5 overflow sticky", d[1], 1'b1);
    csrWr(4'h4, 32'h3);
    csrRd(4'h4, d); check("R5 overflow cleared", d, 32'h0);

    // R6 simultaneous push and pop, partially filled
    sendRsp(2'd3, 7'h0A, 11'h001);
    sendRsp(2'd3, 7'h0B, 11'h002);
    rspValid = 1'b1; rspKind = 2'd3; rspErrStat = 7'h0C; rspTag = 11'h003;
    csrAddr = 4'h0; csrRead = 1'b1;
    #1 d = csrRdata;
    @(negedge clk);
    rspValid = 1'b0; csrRead = 1'b0;
    check("R6 head during push+pop", d, qWord(1'b1, 3'd1, 7'h0A));
    csrRd(4'h0, d); check("R6 second", d, qWord(1'b1, 3'd2, 7'h0B));
    csrRd(4'h0, d); check("R6 pushed", d, qWord(1'b1, 3'd3, 7'h0C));
    csrRd(4'h0, d); check("R6 occupancy kept", d, 32'h0);

    // R6 simultaneous push and pop while full
    for (int i = 0; i < 16; i++) sendRsp(2'd3, 7'(8'h40 + i), 11'(i));
    rspValid = 1'b1; rspKind = 2'd3; rspErrStat = 7'h33; rspTag = 11'h003;
    csrAddr = 4'h0; csrRead = 1'b1;
    #1 d = csrRdata;
    @(negedge clk);
    rspValid = 1'b0; csrRead = 1'b0;
    check("R6 full head", d, qWord(1'b1, 3'd0, 7'h40));
    csrRd(4'h4, d); check("R6 no overflow when full with pop", d[1], 1'b0);
    for (int i = 1; i < 16; i++) begin
      csrRd(4'h0, d); check("R6 full drain", d, qWord(1'b1, 3'(i), 7'(8'h40 + i)));
    end
    csrRd(4'h0, d); check("R6 new entry last", d, qWord(1'b1, 3'd3, 7'h33));
    csrRd(4'h0, d); check("R6 empty after", d, 32'h0);

    // R9 reset mid-operation
    sendRsp(2'd3, 7'h55, 11'h004);
    sendRsp(2'd1, 7'h01, 11'h010);
    doReset();
    csrRd(4'h0, d); check("R9 queue emptied", d, 32'h0);
    csrRd(4'h8, d); check("R9 enable cleared", d, 32'h0);
    csrRd(4'hC, d); check("R9 global cleared", d, 32'h0);
    check("R9 dpValid cleared", {31'b0, dpValid}, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule